// File: doc/BRIEF.md
# Queued SPI Master Controller

This block is an SPI master that works through a list of transfers held in an internal queue. Software does not need to act between words. Each queue slot holds four things: a transmit word, a chip-select pattern, a word length and a delay that follows the transfer. Software fills the slots through a small register port and sets a first and a last slot index. It picks the clock polarity and phase, then issues a start. The controller then shifts each slot's word out on the serial line. At the same time it shifts a word in, full duplex. When the slot completes, the received word overwrites that slot's transmit data.

Without wrap-around, the controller stops after the last slot and raises a sticky done flag. With wrap-around, it returns to the first slot and keeps going. Software can refill slots or clear the wrap bit whenever it chooses. Clearing the wrap bit lets the run finish at the last slot. The chip select stays asserted across slots that share the same pattern and have no delay. In every other case it is released between words.

Top module: `spiq_master`

## Requirements
- R1: Queue slot i (0..15) sits at register address i. Its fields are: [15:0] data, [19:16] one-hot chip select, [23:20] length minus one, [31:24] delay. Address 0x10 is the control register: bit0 start (reads 0), bit1 wrap, bits[3:2] mode. Address 0x11 holds the first slot in [3:0] and the last slot in [7:4]. Address 0x12 is status: bit0 busy, bit1 done. Every written field reads back unchanged.
- R2: A run starts at the first slot and visits slots in ascending order, modulo 16, up to and including the last slot. Each word sends length+1 bits on mosi_o, most significant of those bits first.
- R3: During a slot, the length+1 bits sampled from miso_i are stored right-justified in that slot's data field, with the upper bits zero. This happens once the slot completes.
- R4: The mode value is CPOL*2+CPHA. While the controller is idle, sclk_o rests at CPOL. With CPHA=0, mosi_o is valid before the first edge, the controller samples on leading edges and mosi_o changes only on trailing edges. With CPHA=1, mosi_o changes on leading edges and the controller samples on trailing edges.
- R5: While a slot transfers, cs_no drives the bitwise inverse of that slot's chip-select field (active low).
- R6: The chip select stays asserted from one slot to the next when two conditions hold: the next slot has the same chip-select field, and the finished slot's delay is zero.
- R7: In every other case, all chip selects are released between the two words for at least max(1, delay) SCLK periods. One SCLK period is 2*HALF_CYC clocks.
- R8: Without wrap, the controller stops after the last slot. It then releases all chip selects, clears busy and sets done.
- R9: With wrap set, the slot after the last slot is the first slot again. Clearing wrap during a run makes the run end after its next pass over the last slot.
- R10: Done is sticky and is cleared by writing 1 to status bit1. A start request is ignored while done is set or while the controller is busy.
- R11: A last-slot index smaller than the first-slot index makes the run pass from slot 15 to slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_no | output | 4 | Chip selects, active low |

## Verification
The hardest case to reach from the ports is a wrap-around run that software stops partway through. In that run, slots are transmitted a second time, and their contents are then the words received on the previous pass. The bench reaches it by starting a two-slot wrapping run and waiting until its serial slave model has counted five words. It then clears the wrap bit while the controller is mid-transfer. A behavioural slave tracks every SCLK edge, and the bench also keeps its own model of each slot's data. Together these predict each transmitted word, the release time between words and the final queue contents in all four modes.

// File: rtl/spiq_pkg.sv
`timescale 1ns/1ps
package spiq_pkg;
  localparam int unsigned DW   = 16;
  localparam int unsigned CSW  = 4;
  localparam int unsigned DLYW = 8;
  localparam int unsigned LENW = $clog2(DW);

  typedef struct packed {
    logic [DLYW-1:0] dly;
    logic [LENW-1:0] len;
    logic [CSW-1:0]  cs;
    logic [DW-1:0]   data;
  } entry_t;

  localparam int unsigned REGW = $bits(entry_t);

  typedef enum logic [1:0] {SQ_IDLE, SQ_LOAD, SQ_XFER, SQ_GAP} seq_state_e;
endpackage

// File: rtl/spiq_store.sv
`timescale 1ns/1ps
module spiq_store
  import spiq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          host_we_i,
  input  logic [AW-1:0] host_idx_i,
  input  entry_t        host_wdata_i,
  input  logic [AW-1:0] host_ridx_i,
  output entry_t        host_rdata_o,
  input  logic          eng_we_i,
  input  logic [AW-1:0] eng_widx_i,
  input  logic [DW-1:0] eng_wdata_i,
  input  logic [AW-1:0] eng_ridx_i,
  output entry_t        eng_rdata_o
);
  entry_t q_r [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q_r[i] <= '0;
      end else if (eng_we_i && eng_widx_i == AW'(i)) begin
        // engine write-back wins over a colliding host write
        q_r[i].data <= eng_wdata_i;
      end else if (host_we_i && host_idx_i == AW'(i)) begin
        q_r[i] <= host_wdata_i;
      end
    end
  end

  assign host_rdata_o = q_r[host_ridx_i];
  assign eng_rdata_o  = q_r[eng_ridx_i];
endmodule

// File: rtl/spiq_shift.sv
`timescale 1ns/1ps
module spiq_shift
  import spiq_pkg::*;
#(
  parameter int unsigned HALF_CYC = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            cpol_i,
  input  logic            cpha_i,
  input  logic [DW-1:0]   tx_i,
  input  logic [LENW-1:0] len_i,
  input  logic            miso_i,
  output logic            sclk_o,
  output logic            mosi_o,
  output logic            done_o,
  output logic [DW-1:0]   rx_o
);
  localparam int unsigned HCW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam int unsigned ECW = LENW + 1;

  logic            act_q, sclk_q, mosi_q, done_q;
  logic [HCW-1:0]  hc_q;
  logic [ECW-1:0]  ec_q;
  logic [LENW-1:0] len_q;
  logic [DW-1:0]   sh_q, rx_q, txl;
  logic            tick, lead, smp;

  // left-align so the first bit to send sits at the MSB
  assign txl  = tx_i << (LENW'(DW - 1) - len_i);
  assign tick = act_q && (hc_q == HCW'(HALF_CYC - 1));
  assign lead = ~ec_q[0];
  assign smp  = cpha_i ? ~lead : lead;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      sclk_q <= 1'b0;
      mosi_q <= 1'b0;
      done_q <= 1'b0;
      hc_q   <= '0;
      ec_q   <= '0;
      len_q  <= '0;
      sh_q   <= '0;
      rx_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        act_q  <= 1'b1;
        hc_q   <= '0;
        ec_q   <= '0;
        len_q  <= len_i;
        rx_q   <= '0;
        sclk_q <= cpol_i;
        if (!cpha_i) begin
          mosi_q <= txl[DW-1];
          sh_q   <= {txl[DW-2:0], 1'b0};
        end else begin
          sh_q   <= txl;
        end
      end else if (tick) begin
        hc_q   <= '0;
        sclk_q <= ~sclk_q;
        if (smp) begin
          rx_q <= {rx_q[DW-2:0], miso_i};
        end else begin
          mosi_q <= sh_q[DW-1];
          sh_q   <= {sh_q[DW-2:0], 1'b0};
        end
        if (ec_q == {len_q, 1'b1}) begin
          act_q  <= 1'b0;
          done_q <= 1'b1;
        end else begin
          ec_q <= ec_q + 1'b1;
        end
      end else if (act_q) begin
        hc_q <= hc_q + 1'b1;
      end else begin
        sclk_q <= cpol_i;
      end
    end
  end

  assign sclk_o = sclk_q;
  assign mosi_o = mosi_q;
  assign done_o = done_q;
  assign rx_o   = rx_q;

  // R4: data out never moves on a sampling edge
  p_mosi_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && smp) |=> $stable(mosi_q));
  // R2: one completion pulse per word
  p_done_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !act_q);
endmodule

// File: rtl/spiq_seq.sv
`timescale 1ns/1ps
module spiq_seq
  import spiq_pkg::*;
#(
  parameter int unsigned DEPTH    = 16,
  parameter int unsigned HALF_CYC = 2,
  localparam int unsigned AW      = $clog2(DEPTH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            go_i,
  input  logic            wrap_i,
  input  logic            done_clr_i,
  input  logic [AW-1:0]   first_i,
  input  logic [AW-1:0]   last_i,
  input  entry_t          ent_i,
  output logic [AW-1:0]   ridx_o,
  output logic            wb_we_o,
  output logic [AW-1:0]   wb_idx_o,
  output logic [DW-1:0]   wb_data_o,
  output logic            sh_start_o,
  output logic [DW-1:0]   sh_tx_o,
  output logic [LENW-1:0] sh_len_o,
  input  logic            sh_done_i,
  input  logic [DW-1:0]   sh_rx_i,
  output logic [CSW-1:0]  cs_no,
  output logic            busy_o,
  output logic            done_o
);
  localparam int unsigned GW = DLYW + $clog2(2 * HALF_CYC) + 1;

  seq_state_e      state_q;
  logic [AW-1:0]   ptr_q, nxt_ptr;
  logic [CSW-1:0]  cs_q;
  logic [DLYW-1:0] dly_q;
  logic [GW-1:0]   gap_q, gap_load;
  logic            done_q, at_last, keep_cs;

  assign at_last  = (ptr_q == last_i);
  assign nxt_ptr  = at_last ? first_i :
                    (ptr_q == AW'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
  assign ridx_o   = (state_q == SQ_XFER) ? nxt_ptr : ptr_q;
  assign keep_cs  = (ent_i.cs == cs_q) && (dly_q == '0);
  assign gap_load = GW'(2 * HALF_CYC) * ((dly_q == '0) ? GW'(1) : GW'(dly_q)) - 1'b1;

  assign sh_start_o = (state_q == SQ_LOAD);
  assign sh_tx_o    = ent_i.data;
  assign sh_len_o   = ent_i.len;
  assign wb_we_o    = (state_q == SQ_XFER) && sh_done_i;
  assign wb_idx_o   = ptr_q;
  assign wb_data_o  = sh_rx_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_IDLE;
      ptr_q   <= '0;
      cs_q    <= '0;
      dly_q   <= '0;
      gap_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      if (done_clr_i) done_q <= 1'b0;
      unique case (state_q)
        SQ_IDLE: if (go_i && !done_q) begin
          ptr_q   <= first_i;
          state_q <= SQ_LOAD;
        end
        SQ_LOAD: begin
          cs_q    <= ent_i.cs;
          dly_q   <= ent_i.dly;
          state_q <= SQ_XFER;
        end
        SQ_XFER: if (sh_done_i) begin
          if (at_last && !wrap_i) begin
            cs_q    <= '0;
            done_q  <= 1'b1;
            state_q <= SQ_IDLE;
          end else begin
            ptr_q <= nxt_ptr;
            if (keep_cs) begin
              state_q <= SQ_LOAD;
            end else begin
              cs_q    <= '0;
              gap_q   <= gap_load;
              state_q <= SQ_GAP;
            end
          end
        end
        SQ_GAP: begin
          if (gap_q == '0) state_q <= SQ_LOAD;
          else             gap_q   <= gap_q - 1'b1;
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign cs_no  = ~cs_q;
  assign busy_o = (state_q != SQ_IDLE);
  assign done_o = done_q;

  // R7: chip selects released for the whole gap
  p_gap_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SQ_GAP) |-> (cs_q == '0));
  // R8: done only while stopped
  p_done_stopped_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (state_q == SQ_IDLE));
  // R10: start request ignored while done is pending
  p_go_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_i && done_q && state_q == SQ_IDLE) |=> (state_q == SQ_IDLE));
  // R6: a held select only moves straight into the next load
  p_hold_path_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SQ_XFER && sh_done_i && cs_q != '0 && keep_cs && !(at_last && !wrap_i))
      |=> (state_q == SQ_LOAD && $stable(cs_q)));
endmodule

// File: rtl/spiq_master.sv
`timescale 1ns/1ps
module spiq_master
  import spiq_pkg::*;
#(
  parameter int unsigned DEPTH    = 16,
  parameter int unsigned HALF_CYC = 2,
  localparam int unsigned AW      = $clog2(DEPTH),
  localparam int unsigned ADDR_W  = AW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REGW-1:0]   reg_wdata_i,
  output logic [REGW-1:0]   reg_rdata_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [CSW-1:0]    cs_no
);
  localparam logic [ADDR_W-1:0] ADR_CTRL = {1'b1, AW'(0)};
  localparam logic [ADDR_W-1:0] ADR_PTR  = {1'b1, AW'(1)};
  localparam logic [ADDR_W-1:0] ADR_STAT = {1'b1, AW'(2)};

  logic          is_q, wr_ctrl, wr_ptr, go, done_clr, busy, done;
  logic          wrap_q;
  logic [1:0]    mode_q;
  logic [AW-1:0] first_q, last_q;

  entry_t          host_rd, eng_rd;
  logic [AW-1:0]   eng_ridx, wb_idx;
  logic            wb_we, sh_start, sh_done;
  logic [DW-1:0]   wb_data, sh_tx, sh_rx;
  logic [LENW-1:0] sh_len;

  assign is_q     = ~reg_addr_i[ADDR_W-1];
  assign wr_ctrl  = reg_we_i && (reg_addr_i == ADR_CTRL);
  assign wr_ptr   = reg_we_i && (reg_addr_i == ADR_PTR);
  assign go       = wr_ctrl && reg_wdata_i[0];
  assign done_clr = reg_we_i && (reg_addr_i == ADR_STAT) && reg_wdata_i[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wrap_q  <= 1'b0;
      mode_q  <= '0;
      first_q <= '0;
      last_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        wrap_q <= reg_wdata_i[1];
        if (!busy) mode_q <= reg_wdata_i[3:2];
      end
      if (wr_ptr && !busy) begin
        first_q <= reg_wdata_i[AW-1:0];
        last_q  <= reg_wdata_i[2*AW-1:AW];
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (is_q) begin
      reg_rdata_o = host_rd;
    end else begin
      unique case (reg_addr_i)
        ADR_CTRL: reg_rdata_o[3:1]      = {mode_q, wrap_q};
        ADR_PTR:  reg_rdata_o[2*AW-1:0] = {last_q, first_q};
        ADR_STAT: reg_rdata_o[1:0]      = {done, busy};
        default:  reg_rdata_o           = '0;
      endcase
    end
  end

  spiq_store #(.DEPTH(DEPTH)) u_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .host_we_i    (reg_we_i && is_q),
    .host_idx_i   (reg_addr_i[AW-1:0]),
    .host_wdata_i (entry_t'(reg_wdata_i)),
    .host_ridx_i  (reg_addr_i[AW-1:0]),
    .host_rdata_o (host_rd),
    .eng_we_i     (wb_we),
    .eng_widx_i   (wb_idx),
    .eng_wdata_i  (wb_data),
    .eng_ridx_i   (eng_ridx),
    .eng_rdata_o  (eng_rd)
  );

  spiq_seq #(.DEPTH(DEPTH), .HALF_CYC(HALF_CYC)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .go_i       (go),
    .wrap_i     (wrap_q),
    .done_clr_i (done_clr),
    .first_i    (first_q),
    .last_i     (last_q),
    .ent_i      (eng_rd),
    .ridx_o     (eng_ridx),
    .wb_we_o    (wb_we),
    .wb_idx_o   (wb_idx),
    .wb_data_o  (wb_data),
    .sh_start_o (sh_start),
    .sh_tx_o    (sh_tx),
    .sh_len_o   (sh_len),
    .sh_done_i  (sh_done),
    .sh_rx_i    (sh_rx),
    .cs_no      (cs_no),
    .busy_o     (busy),
    .done_o     (done)
  );

  spiq_shift #(.HALF_CYC(HALF_CYC)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (sh_start),
    .cpol_i  (mode_q[1]),
    .cpha_i  (mode_q[0]),
    .tx_i    (sh_tx),
    .len_i   (sh_len),
    .miso_i  (miso_i),
    .sclk_o  (sclk_o),
    .mosi_o  (mosi_o),
    .done_o  (sh_done),
    .rx_o    (sh_rx)
  );

  // R4: clock rests at the polarity while stopped
  p_sclk_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && $past(!busy) && $stable(mode_q)) |-> (sclk_o == mode_q[1]));
  // R8: no select while stopped
  p_cs_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> (cs_no == '1));
endmodule

// File: tb/spiq_master_tb_top.sv
`timescale 1ns/1ps
module spiq_master_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        sclk, mosi, miso;
  logic [3:0]  cs_n;

  spiq_master dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .sclk_o(sclk),
    .mosi_o(mosi), .miso_i(miso), .cs_no(cs_n)
  );

  always #4 clk_i = ~clk_i;

  int nchk = 0, nerr = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bench model of the queue
  logic [15:0] m_data [16];
  logic [3:0]  m_cs   [16];
  logic [3:0]  m_len  [16];
  logic [7:0]  m_dly  [16];
  int first_m, last_m;
  bit wrap_m, cpol_m, cpha_m, run_mon;

  // serial slave model state
  int  e_cur, ec, wcnt, words_run, rel_cnt, exp_min;
  bit  prev_sclk, cs_bad, rel_seen, exp_rel, miso_r;
  logic [15:0] cap;

  assign miso = miso_r;

  function automatic logic [15:0] spat(input int w);
    return 16'h5A3C ^ 16'(w * 16'h0B73) ^ 16'(w << 5);
  endfunction

  always @(negedge clk_i) begin
    int n, idx;
    bit lead;
    logic [15:0] mask, sw;
    if (run_mon) begin
      if (cs_n == 4'hF) begin rel_seen = 1; rel_cnt++; end
      if (sclk != prev_sclk) begin
        n = int'(m_len[e_cur]) + 1;
        if (ec == 0 && words_run > 0) begin
          if (exp_rel) check(rel_seen == 1 && rel_cnt >= exp_min, "R7", rel_cnt, exp_min);
          else         check(rel_seen == 0, "R6", rel_seen, 0);
        end
        lead = (prev_sclk == cpol_m);
        if ((cpha_m == 0) == lead) begin
          cap = {cap[14:0], mosi};
          if (cs_n != ~m_cs[e_cur]) cs_bad = 1;
        end
        ec++;
        if (ec == 2 * n) begin
          mask = 16'((32'd1 << n) - 1);
          check((cap & mask) == (m_data[e_cur] & mask), "R2", cap & mask, m_data[e_cur] & mask);
          check(!cs_bad, "R5", e_cur, m_cs[e_cur]);
          m_data[e_cur] = spat(wcnt) & mask;
          exp_rel = (e_cur == last_m && !wrap_m) || (m_dly[e_cur] != 0);
          exp_min = 4 * ((m_dly[e_cur] == 0) ? 1 : int'(m_dly[e_cur]));
          e_cur = (e_cur == last_m) ? first_m : (e_cur + 1) % 16;
          if (m_cs[e_cur] != m_cs[(e_cur + 15) % 16] && !(e_cur == first_m)) exp_rel = 1;
          wcnt++; words_run++; ec = 0; cap = '0; cs_bad = 0; rel_seen = 0; rel_cnt = 0;
        end
      end
      prev_sclk = sclk;
      n   = int'(m_len[e_cur]) + 1;
      idx = cpha_m ? ((ec > 0) ? (ec - 1) / 2 : -1) : ec / 2;
      sw  = spat(wcnt);
      miso_r = (idx >= 0 && idx < n) ? sw[n - 1 - idx] : 1'b0;
    end
  end

  task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk_i); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk_i); reg_we = 0;
  endtask

  task automatic rd_reg(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk_i); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic load_slot(input int i, input logic [15:0] d, input logic [3:0] c,
                           input logic [3:0] l, input logic [7:0] y);
    m_data[i] = d; m_cs[i] = c; m_len[i] = l; m_dly[i] = y;
    wr_reg(5'(i), {y, l, c, d});
  endtask

  task automatic wait_idle(output bit ok);
    logic [31:0] s;
    ok = 0;
    for (int k = 0; k < 40000; k++) begin
      rd_reg(5'h12, s);
      if (!s[0]) begin ok = 1; break; end
    end
  endtask

  task automatic start_run(input int f, input int l, input int mode, input bit wr);
    first_m = f; last_m = l; cpol_m = mode[1]; cpha_m = mode[0]; wrap_m = wr;
    wr_reg(5'h11, 32'(l << 4 | f));
    wr_reg(5'h10, 32'(mode << 2 | int'(wr) << 1));
    repeat (3) @(negedge clk_i);
    e_cur = f; ec = 0; words_run = 0; cap = '0; cs_bad = 0; rel_seen = 0; rel_cnt = 0;
    prev_sclk = sclk; run_mon = 1;
    wr_reg(5'h10, 32'(mode << 2 | int'(wr) << 1 | 1));
  endtask

  task automatic finish_run(input int exp_words, input string wreq);
    bit ok;
    logic [31:0] s;
    wait_idle(ok);
    check(ok, "R8", 0, 1);
    repeat (2) @(negedge clk_i);
    run_mon = 0;
    rd_reg(5'h12, s);
    check(s[1:0] == 2'b10, "R8", s[1:0], 2);
    check(cs_n == 4'hF, "R8", cs_n, 4'hF);
    check(sclk == cpol_m, "R4", sclk, cpol_m);
    if (exp_words > 0) check(words_run == exp_words, wreq, words_run, exp_words);
    for (int i = 0; i < 16; i++) begin
      rd_reg(5'(i), s);
      check(s[15:0] == m_data[i], "R3", s[15:0], m_data[i]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    check(0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [31:0] s;
    bit ok;
    miso_r = 0; run_mon = 0; wcnt = 0;
    for (int i = 0; i < 16; i++) begin m_data[i] = 0; m_cs[i] = 0; m_len[i] = 0; m_dly[i] = 0; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    rd_reg(5'h12, s); check(s == 0, "R8", s, 0);
    check(cs_n == 4'hF && sclk == 0 && mosi == 0, "R4", {cs_n, sclk, mosi}, 6'h3C);
    rd_reg(5'h03, s); check(s == 0, "R1", s, 0);

    // sweep all four modes over a full 16-slot queue
    for (int m = 0; m < 4; m++) begin
      for (int i = 0; i < 16; i++)
        load_slot(i, 16'hC3A5 ^ 16'(i * 16'h1357) ^ 16'(m),
                  4'(1 << ((i >> 1) & 3)), 4'((i * 5 + m) & 15),
                  (i % 3 == 2) ? 8'((i & 3) + 1) : 8'd0);
      if (m == 0) begin
        for (int i = 0; i < 16; i++) begin
          rd_reg(5'(i), s);
          check(s == {m_dly[i], m_len[i], m_cs[i], m_data[i]}, "R1", s,
                {m_dly[i], m_len[i], m_cs[i], m_data[i]});
        end
      end
      start_run(0, 15, m, 0);
      finish_run(16, "R2");
      rd_reg(5'h11, s); check(s[7:0] == 8'hF0, "R1", s, 32'hF0);
      rd_reg(5'h10, s); check(s[3:0] == 4'(m << 2), "R1", s, m << 2);
      if (m == 1) begin
        // start while done pending is ignored
        wr_reg(5'h10, 32'(m << 2 | 1));
        for (int k = 0; k < 20; k++) begin
          @(negedge clk_i);
          if (sclk != cpol_m || cs_n != 4'hF) begin check(0, "R10", sclk, cpol_m); break; end
        end
        rd_reg(5'h12, s); check(s[1:0] == 2'b10, "R10", s, 2);
      end
      wr_reg(5'h12, 32'h2);
      rd_reg(5'h12, s); check(s[1:0] == 2'b00, "R10", s, 0);
    end

    // pointer runs through slot 15 to slot 0
    start_run(14, 1, 2, 0);
    finish_run(4, "R11");
    wr_reg(5'h12, 32'h2);

    // wrap-around, stopped mid-run by clearing wrap
    load_slot(2, 16'h8E17, 4'h2, 4'd7, 8'd0);
    load_slot(3, 16'h31F0, 4'h8, 4'd11, 8'd1);
    start_run(2, 3, 3, 1);
    for (int k = 0; k < 20000 && words_run < 5; k++) @(negedge clk_i);
    wrap_m = 0;
    wr_reg(5'h10, 32'(3 << 2));
    finish_run(0, "R9");
    check(words_run >= 6 && words_run % 2 == 0, "R9", words_run, 6);
    check(e_cur == 2, "R9", e_cur, 2);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule